// File: doc/BRIEF.md
# RTC Update Request Handshake Controller

This block holds the control word of a real-time clock and runs the handshake that lets software stop the clock counters, reload them, and restart them safely. Software sets a request bit for the time domain (seconds, minutes, hours), for the calendar domain (day, date, month, year, century), or for both. The matching freeze output goes high in the next cycle and stops that domain's counting. On the first one-second tick seen while the request is pending, the domain is granted and a shared acknowledge flag rises. From then on, load strobes for that domain pass through to the counters. Writing 0 to the request bit ends the procedure: the freeze drops and the grant is withdrawn.

The control word also stores two 2-bit event-select fields, which go straight out to a separate event flag generator. While the write-protect input is high, the whole control word is locked against writes. The counters, alarms and interrupts live outside this block.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: After reset, the control word, both freeze outputs, the acknowledge flag, both event-select outputs and both load-pass outputs are all 0.
- R2: A write with `bus_we_i` high at address 0 loads the control word. Bit 0 is the time request, bit 1 the calendar request, bits 9:8 the time event select and bits 17:16 the calendar event select. `bus_rdata_o` returns the word at address 0 combinationally, with every other bit reading 0. A write to any other address changes nothing, and reads of other addresses return 0.
- R3: While `wp_en_i` is high, writes to the control word are ignored.
- R4: `tim_freeze_o` equals the stored time request bit, so it changes in the cycle after the accepted write.
- R5: `cal_freeze_o` equals the stored calendar request bit, so it changes in the cycle after the accepted write.
- R6: A domain is granted, and `ack_o` sets, at the first clock edge with `sec_tick_i` high while that domain's request is already stored and not yet granted. A tick at the same edge as the request write does not grant.
- R7: Once set, `ack_o` stays high until an edge with `ack_clr_i` high. If a grant happens at the same edge, the grant wins.
- R8: Writing 0 to a stored request bit drops its freeze in the next cycle and withdraws the grant, including when the domain is still pending. Writing 0 to a request bit that is already 0 leaves the freeze low and leaves `ack_o` unchanged.
- R9: `tim_load_ok_o` and `cal_load_ok_o` follow `tim_load_i` and `cal_load_i` only while the matching domain is granted. At all other times they stay 0.
- R10: The time and calendar handshakes are independent: each has its own request, grant and withdrawal, and either one or both may be active at the same time.
- R11: `tim_evsel_o` and `cal_evsel_o` always equal the stored event-select fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| wp_en_i | input | 1 | Write-protect enable |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| ack_clr_i | input | 1 | Clears the acknowledge flag |
| tim_load_i | input | 1 | Software load strobe for the time counters |
| cal_load_i | input | 1 | Software load strobe for the calendar counters |
| tim_freeze_o | output | 1 | Stops time counting |
| cal_freeze_o | output | 1 | Stops calendar counting |
| ack_o | output | 1 | Update acknowledge flag |
| tim_load_ok_o | output | 1 | Load strobe passed to the time counters |
| cal_load_ok_o | output | 1 | Load strobe passed to the calendar counters |
| tim_evsel_o | output | 2 | Time event select |
| cal_evsel_o | output | 2 | Calendar event select |

## Verification
A wrong stored control word shows on `bus_rdata_o`, on a freeze output or on an event select in the cycle after the write that caused it.

A wrong grant state stays hidden until it matters:
- It shows as an early or missing rise of `ack_o` at the first tick edge.
- It shows as a load strobe that passes or is blocked in the same cycle it is driven.

The bench therefore pulses ticks and load strobes around every request change, including the edges where they coincide. It compares all outputs against its model after every clock.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  localparam int unsigned NDOM     = 2;
  localparam int unsigned DOM_TIM  = 0;
  localparam int unsigned DOM_CAL  = 1;
  localparam int unsigned SEL_W    = 2;
  // field positions decoded by software
  localparam int unsigned TIM_REQ_B = 0;
  localparam int unsigned CAL_REQ_B = 1;
  localparam int unsigned TIM_SEL_L = 8;
  localparam int unsigned CAL_SEL_L = 16;

  typedef struct packed {
    logic [SEL_W-1:0] cal_sel;
    logic [SEL_W-1:0] tim_sel;
    logic [NDOM-1:0]  req;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_upd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_OFF = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_en_i,
  output ctrl_t             ctrl_q_o,
  output ctrl_t             ctrl_d_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CTRL_OFF);

  ctrl_t ctrl_q, ctrl_d;
  logic  hit, wr_en;

  assign hit   = (addr_i == OFF);
  assign wr_en = we_i && hit && !wp_en_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.req[DOM_TIM] = wdata_i[TIM_REQ_B];
      ctrl_d.req[DOM_CAL] = wdata_i[CAL_REQ_B];
      ctrl_d.tim_sel      = wdata_i[TIM_SEL_L +: SEL_W];
      ctrl_d.cal_sel      = wdata_i[CAL_SEL_L +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[TIM_REQ_B]             = ctrl_q.req[DOM_TIM];
      rdata_o[CAL_REQ_B]             = ctrl_q.req[DOM_CAL];
      rdata_o[TIM_SEL_L +: SEL_W]    = ctrl_q.tim_sel;
      rdata_o[CAL_SEL_L +: SEL_W]    = ctrl_q.cal_sel;
    end
  end

  assign ctrl_q_o = ctrl_q;
  assign ctrl_d_o = ctrl_d;
endmodule

// File: rtl/rtc_upd_grant.sv
module rtc_upd_grant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_q_i,   // stored request
  input  logic req_d_i,   // request after this edge
  input  logic tick_i,
  input  logic load_i,
  output logic grant_o,
  output logic grant_ev_o,
  output logic load_ok_o
);
  logic granted_q, granted_d;

  // pending = stored, not yet granted; withdrawal beats a coincident tick
  assign grant_ev_o = req_q_i && !granted_q && tick_i && req_d_i;
  assign granted_d  = req_d_i && (granted_q || grant_ev_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) granted_q <= 1'b0;
    else         granted_q <= granted_d;
  end

  assign grant_o   = granted_q;
  assign load_ok_o = load_i && granted_q;
endmodule

// File: rtl/rtc_ack_flag.sv
module rtc_ack_flag #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_i,
  output logic            flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (|set_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_OFF = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              wp_en_i,
  input  logic              sec_tick_i,
  input  logic              ack_clr_i,
  input  logic              tim_load_i,
  input  logic              cal_load_i,
  output logic              tim_freeze_o,
  output logic              cal_freeze_o,
  output logic              ack_o,
  output logic              tim_load_ok_o,
  output logic              cal_load_ok_o,
  output logic [1:0]        tim_evsel_o,
  output logic [1:0]        cal_evsel_o
);
  ctrl_t           ctrl_q, ctrl_d;
  logic [NDOM-1:0] load_in, load_ok, grant, grant_ev;

  rtc_ctrl_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTRL_OFF(CTRL_OFF)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .wp_en_i (wp_en_i),
    .ctrl_q_o(ctrl_q),
    .ctrl_d_o(ctrl_d),
    .rdata_o (bus_rdata_o)
  );

  assign load_in[DOM_TIM] = tim_load_i;
  assign load_in[DOM_CAL] = cal_load_i;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    rtc_upd_grant u_grant (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_q_i   (ctrl_q.req[d]),
      .req_d_i   (ctrl_d.req[d]),
      .tick_i    (sec_tick_i),
      .load_i    (load_in[d]),
      .grant_o   (grant[d]),
      .grant_ev_o(grant_ev[d]),
      .load_ok_o (load_ok[d])
    );
  end

  rtc_ack_flag #(.NSRC(NDOM)) u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (grant_ev),
    .clr_i (ack_clr_i),
    .flag_o(ack_o)
  );

  assign tim_freeze_o  = ctrl_q.req[DOM_TIM];
  assign cal_freeze_o  = ctrl_q.req[DOM_CAL];
  assign tim_load_ok_o = load_ok[DOM_TIM];
  assign cal_load_ok_o = load_ok[DOM_CAL];
  assign tim_evsel_o   = ctrl_q.tim_sel;
  assign cal_evsel_o   = ctrl_q.cal_sel;
endmodule

// File: rtl/rtc_upd_ctrl_chk.sv
module rtc_upd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_we_i,
  input logic wp_en_i,
  input logic sec_tick_i,
  input logic ack_clr_i,
  input logic tim_load_i,
  input logic cal_load_i,
  input logic tim_freeze_o,
  input logic cal_freeze_o,
  input logic ack_o,
  input logic tim_load_ok_o,
  input logic cal_load_ok_o
);
  // R3: no freeze change while protected
  a_r3_wp_tim_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_en_i) |-> tim_freeze_o == $past(tim_freeze_o));
  a_r3_wp_cal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_en_i) |-> cal_freeze_o == $past(cal_freeze_o));
  // R4 R5: freeze only moves after a write
  a_r4_tim_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tim_freeze_o != $past(tim_freeze_o)) |-> $past(bus_we_i));
  a_r5_cal_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_freeze_o != $past(cal_freeze_o)) |-> $past(bus_we_i));
  // R6: ack rises only on a tick with a request stored
  a_r6_ack_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(sec_tick_i) && ($past(tim_freeze_o) || $past(cal_freeze_o)));
  // R7: clear without tick drops the flag
  a_r7_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ack_clr_i) && !$past(sec_tick_i) |-> !ack_o);
  // R9: load passes only under freeze and with a strobe
  a_r9_tim_load_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tim_load_ok_o |-> tim_freeze_o && tim_load_i);
  a_r9_cal_load_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_load_ok_o |-> cal_freeze_o && cal_load_i);
endmodule

bind rtc_upd_ctrl rtc_upd_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .wp_en_i      (wp_en_i),
  .sec_tick_i   (sec_tick_i),
  .ack_clr_i    (ack_clr_i),
  .tim_load_i   (tim_load_i),
  .cal_load_i   (cal_load_i),
  .tim_freeze_o (tim_freeze_o),
  .cal_freeze_o (cal_freeze_o),
  .ack_o        (ack_o),
  .tim_load_ok_o(tim_load_ok_o),
  .cal_load_ok_o(cal_load_ok_o)
);

// File: tb/rtc_upd_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_upd_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, wp = 0, tick = 0, clr = 0, tl = 0, cl = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        tfz, cfz, ack, tok, cok;
  logic [1:0]  tsel, csel;

  int checks = 0, errors = 0;

  // reference state
  int unsigned m_ctrl = 0;
  bit m_gt = 0, m_gc = 0, m_ack = 0;

  always #10 clk = ~clk;

  rtc_upd_ctrl u_rtc_upd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wp_en_i(wp),
    .sec_tick_i(tick), .ack_clr_i(clr), .tim_load_i(tl), .cal_load_i(cl),
    .tim_freeze_o(tfz), .cal_freeze_o(cfz), .ack_o(ack),
    .tim_load_ok_o(tok), .cal_load_ok_o(cok),
    .tim_evsel_o(tsel), .cal_evsel_o(csel)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model update at each edge, compare 5 ns later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_gt = 0; m_gc = 0; m_ack = 0;
    end else begin
      int unsigned nc;
      bit ev_t, ev_c;
      nc = m_ctrl;
      if (we && !wp && addr == 0) nc = wdata & 32'h0003_0303;
      ev_t = m_ctrl[0] && !m_gt && tick && nc[0];
      ev_c = m_ctrl[1] && !m_gc && tick && nc[1];
      m_gt = nc[0] && (m_gt || ev_t);
      m_gc = nc[1] && (m_gc || ev_c);
      if (ev_t || ev_c) m_ack = 1;
      else if (clr)     m_ack = 0;
      m_ctrl = nc;
      #5;
      chk("R2 rdata", rdata, (addr == 0) ? m_ctrl : 0);
      chk("R4 tim_freeze", tfz, m_ctrl[0]);
      chk("R5 cal_freeze", cfz, m_ctrl[1]);
      chk("R6 ack", ack, m_ack);
      chk("R9 tim_load_ok", tok, tl && m_gt);
      chk("R9 cal_load_ok", cok, cl && m_gc);
      chk("R11 tim_evsel", tsel, m_ctrl[9:8]);
      chk("R11 cal_evsel", csel, m_ctrl[17:16]);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 0);
    chk("R1 reset freeze", {tfz, cfz, ack, tok, cok}, 0);
    chk("R1 reset evsel", {tsel, csel}, 0);
    rst_n = 1;
    idle(2);

    // R2 field packing and ignored bits
    wr(8'h00, 32'hFFFF_FC00 | 32'h0002_0100);
    chk("R2 masked", rdata, 32'h0003_0300 & 32'hFFFF_FC00 | 32'h0002_0100 & 32'h0003_0300);
    wr(8'h04, 32'h0000_0003);
    chk("R2 other addr no write", {tfz, cfz}, 0);
    addr = 8'h04; #1; chk("R2 other addr reads 0", rdata, 0); addr = 0;

    // R8 zero write when idle
    wr(8'h00, 32'h0);
    chk("R8 idle zero", {tfz, ack}, 0);

    // R4 R6 time request, tick at same edge as write does not grant
    @(negedge clk); we = 1; wdata = 32'h1; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    chk("R4 freeze up", tfz, 1);
    chk("R6 no grant at write edge", ack, 0);
    @(negedge clk); tl = 1; @(negedge clk); tl = 0;
    pulse_tick();
    chk("R6 ack after tick", ack, 1);
    @(negedge clk); tl = 1; #6; chk("R9 load passes", tok, 1); @(negedge clk); tl = 0;
    @(negedge clk); cl = 1; #6; chk("R9 cal load blocked", cok, 0); @(negedge clk); cl = 0;

    // R7 clear, and set beating clear
    pulse_clr();
    chk("R7 cleared", ack, 0);
    idle(2);
    chk("R7 stays clear", ack, 0);

    // R10 calendar on top of time
    wr(8'h00, 32'h3);
    chk("R5 cal freeze", cfz, 1);
    chk("R10 time kept", tfz, 1);
    @(negedge clk); tick = 1; clr = 1;
    @(negedge clk); tick = 0; clr = 0;
    chk("R7 set wins", ack, 1);

    // R3 write protect
    @(negedge clk); wp = 1;
    wr(8'h00, 32'h0);
    chk("R3 protected", {tfz, cfz}, 2'b11);
    @(negedge clk); wp = 0;

    // R8 withdraw time only
    wr(8'h00, 32'h2);
    chk("R8 time released", tfz, 0);
    @(negedge clk); tl = 1; cl = 1; #6;
    chk("R8 grant gone", tok, 0);
    chk("R10 cal still granted", cok, 1);
    @(negedge clk); tl = 0; cl = 0;

    // R8 withdraw while pending, tick on same edge
    pulse_clr();
    wr(8'h00, 32'h1);
    @(negedge clk); we = 1; wdata = 32'h0; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    chk("R8 withdraw beats tick", ack, 0);
    chk("R8 freeze down", tfz, 0);

    // R11 event selects
    wr(8'h00, 32'h0001_0200);
    chk("R11 sel", {tsel, csel}, 4'b1001);
    wr(8'h00, 32'h0003_0300);
    chk("R11 sel max", {tsel, csel}, 4'b1111);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule